// File: doc/BRIEF.md
# Sleep-State Request Resolver

This block sits between a hardware thread and the core power controller. It accepts two kinds of low-power entry request and turns either one into a single resolved sleep-state request. The first kind is an explicit wait request. It carries a hinted state number, a sub-state value and a break-control bit. The second kind is an I/O port read. The block captures such a read when its address falls inside a programmable window, given as a base and a range. A captured read is treated as a request for the deepest core sleep state.

Both kinds of request go through the same clipping stage. A configuration bit vector says which states 0 to 15 the part supports. A hint for an unsupported state is moved up to the nearest supported state that is deeper than the hint. If no supported state is deeper, the hint falls back to the deepest supported state.

The result is registered and presented for one cycle with a valid strobe. I/O reads that fall outside the window are not turned into requests. Instead they are reported on a separate one-cycle pass-through strobe, so that they can be serviced as ordinary port reads.

Top module: `sleep_req_resolver`

## Requirements
- R1: A wait request sampled at a clock edge (`wait_vld`=1) produces `req_vld`=1 for exactly one cycle after that edge. In that cycle, `req_sub` equals `wait_sub` and `req_brk` equals `wait_brk`. A sub-state moved up by clipping is not changed.
- R2: If the hinted state is not set in `supported` (bit i = state i supported), `req_state` is the lowest supported state above the hint. For example, hint 9 with supported states 0..6 and 10 gives 10.
- R3: If no supported state is at or above the hint, `req_state` is the highest supported state. For example, hint 9 with supported states 0..6 gives 6. If `supported` is all zero, `req_state` is 0.
- R4: A hinted state whose bit is set in `supported` is passed through as `req_state` unchanged.
- R5: An I/O read (`io_rd_vld`=1) is in the window when `win_base` <= `io_addr` < `win_base`+`win_range`. The sum is evaluated one bit wider than the address, so it cannot wrap. An in-window read produces a request for state 6, clipped as in R2/R3. The request has `req_sub`=0 and `req_brk`=1, whatever the wait-path inputs are. `req_brk`=1 means break on interrupts even while interrupts are masked.
- R6: An I/O read outside the window (including any read when `win_range`=0) produces no request. It raises `io_pass` for one cycle after the sampling edge.
- R7: When a wait request and an I/O read are sampled in the same cycle, the request is built from the wait inputs. The I/O read is dropped if it was in the window, and is passed through on `io_pass` if it was outside.
- R8: After reset, and in any cycle after an edge that sampled no request input, `req_vld` and `io_pass` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_vld | input | 1 | Wait request present |
| wait_state | input | 4 | Hinted sleep state |
| wait_sub | input | 4 | Requested sub-state |
| wait_brk | input | 1 | Break on interrupts while masked |
| io_rd_vld | input | 1 | I/O port read present |
| io_addr | input | 16 | I/O port address |
| win_base | input | 16 | Capture window base address |
| win_range | input | 16 | Capture window size in ports |
| supported | input | 16 | Supported-state mask, bit i = state i |
| req_vld | output | 1 | One-cycle resolved request strobe |
| req_state | output | 4 | Resolved sleep state |
| req_sub | output | 4 | Resolved sub-state |
| req_brk | output | 1 | Resolved break mode |
| io_pass | output | 1 | One-cycle strobe for an uncaptured I/O read |

## Verification
The bench targets the edges of the clipping search. It uses a hint above every supported state, a hint exactly on the top supported state, and an empty mask. A resolver that searched only upward would return a stale or zero state in these cases. One that searched downward would return a shallower state than the hint.

Window tests use a base near the top of the address space with a range that crosses it. They also cover the addresses at `win_base` and `win_base`+`win_range`-1, and a zero range. An adder that wraps would capture low addresses by mistake. An off-by-one compare would capture or drop the end ports.

Same-cycle collisions check that the explicit hint's sub-state and break bit win. Redirected reads check that sub-state 0 and break mode 1 are forced.

// File: rtl/sleep_req_resolver.sv
module sleep_req_resolver #(
  parameter int ADDR_W   = 16,
  parameter int ST_W     = 4,
  parameter int SUB_W    = 4,
  parameter int IO_STATE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_vld,
  input  logic [ST_W-1:0]   wait_state,
  input  logic [SUB_W-1:0]  wait_sub,
  input  logic              wait_brk,
  input  logic              io_rd_vld,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_range,
  input  logic [(1<<ST_W)-1:0] supported,
  output logic              req_vld,
  output logic [ST_W-1:0]   req_state,
  output logic [SUB_W-1:0]  req_sub,
  output logic              req_brk,
  output logic              io_pass
);
  localparam int NST = 1 << ST_W;
  localparam logic [ST_W-1:0] IO_HINT = ST_W'(IO_STATE);

  logic [ADDR_W:0] win_end;
  logic            in_win, io_take;
  logic [ST_W-1:0] hint, up_st, top_st, clip_st;
  logic            up_hit;

  assign win_end = {1'b0, win_base} + {1'b0, win_range};
  assign in_win  = (io_addr >= win_base) && ({1'b0, io_addr} < win_end);
  assign io_take = io_rd_vld && in_win && !wait_vld;
  assign hint    = wait_vld ? wait_state : IO_HINT;

  always_comb begin
    up_st  = '0;
    up_hit = 1'b0;
    top_st = '0;
    for (int i = NST-1; i >= 0; i--)
      if (supported[i] && (ST_W'(i) >= hint)) begin
        up_st  = ST_W'(i);
        up_hit = 1'b1;
      end
    for (int i = 0; i < NST; i++)
      if (supported[i]) top_st = ST_W'(i);
  end

  assign clip_st = up_hit ? up_st : top_st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_vld   <= 1'b0;
      req_state <= '0;
      req_sub   <= '0;
      req_brk   <= 1'b0;
      io_pass   <= 1'b0;
    end else begin
      req_vld <= wait_vld || io_take;
      io_pass <= io_rd_vld && !in_win;
      if (wait_vld || io_take) begin
        req_state <= clip_st;
        req_sub   <= wait_vld ? wait_sub : '0;
        req_brk   <= wait_vld ? wait_brk : 1'b1;
      end
    end
  end
endmodule

// File: rtl/sleep_req_resolver_chk.sv
module sleep_req_resolver_chk #(
  parameter int ST_W  = 4,
  parameter int SUB_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wait_vld,
  input logic [ST_W-1:0]   wait_state,
  input logic [SUB_W-1:0]  wait_sub,
  input logic              wait_brk,
  input logic              io_rd_vld,
  input logic [(1<<ST_W)-1:0] supported,
  input logic              req_vld,
  input logic [ST_W-1:0]   req_state,
  input logic [SUB_W-1:0]  req_sub,
  input logic              req_brk,
  input logic              io_pass
);
  logic [(1<<ST_W)-1:0] sup_q;
  always_ff @(posedge clk) sup_q <= supported;

  // R1
  a_r1_wait_fields: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && $past(wait_vld) |-> req_sub == $past(wait_sub) && req_brk == $past(wait_brk));
  // R2, R3
  a_r2_state_supported: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && (sup_q != '0) |-> sup_q[req_state]);
  // R4
  a_r4_keep_supported: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && $past(wait_vld) && sup_q[$past(wait_state)] |-> req_state == $past(wait_state));
  // R5
  a_r5_io_forced: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && !$past(wait_vld) |-> req_sub == '0 && req_brk);
  // R6
  a_r6_pass_cause: assert property (@(posedge clk) disable iff (!rst_n)
    io_pass |-> $past(io_rd_vld));
  // R8
  a_r8_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> $past(wait_vld || io_rd_vld));
endmodule

bind sleep_req_resolver sleep_req_resolver_chk #(.ST_W(ST_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_vld(wait_vld), .wait_state(wait_state),
  .wait_sub(wait_sub), .wait_brk(wait_brk), .io_rd_vld(io_rd_vld),
  .supported(supported), .req_vld(req_vld), .req_state(req_state),
  .req_sub(req_sub), .req_brk(req_brk), .io_pass(io_pass));

// File: tb/test_sleep_req_resolver.sv
module test_sleep_req_resolver;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_vld = 0, wait_brk = 0, io_rd_vld = 0;
  logic [3:0] wait_state = 0, wait_sub = 0;
  logic [15:0] io_addr = 0, win_base = 0, win_range = 0, supported = 0;
  logic req_vld, req_brk, io_pass;
  logic [3:0] req_state, req_sub;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sleep_req_resolver i_sleep_req_resolver (.*);

  function automatic logic [3:0] clip(input logic [3:0] h, input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i] && i >= h) return 4'(i);
    for (int i = 15; i >= 0; i--) if (m[i]) return 4'(i);
    return 4'd0;
  endfunction

  function automatic bit inwin(input logic [15:0] a, b, r);
    return (32'(a) >= 32'(b)) && (32'(a) < 32'(b) + 32'(r));
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // drive at negedge, expected values one edge later, sampled at next negedge
  task automatic step(input bit wv, input logic [3:0] ws, wsub, input bit wb,
                      input bit iv, input logic [15:0] a);
    bit ev, ep, w;
    logic [3:0] es, esub;
    bit eb;
    wait_vld = wv; wait_state = ws; wait_sub = wsub; wait_brk = wb;
    io_rd_vld = iv; io_addr = a;
    w  = iv && inwin(a, win_base, win_range);
    ev = wv || w;
    ep = iv && !inwin(a, win_base, win_range);
    es = clip(wv ? ws : 4'd6, supported);
    esub = wv ? wsub : 4'd0;
    eb = wv ? wb : 1'b1;
    @(negedge clk);
    chk(wv ? "R1 R7 req_vld" : (iv ? "R5 R6 req_vld" : "R8 req_vld"), req_vld, ev);
    chk("R6 R7 io_pass", io_pass, ep);
    if (ev) begin
      chk("R2 R3 R4 req_state", req_state, es);
      chk(wv ? "R1 req_sub" : "R5 req_sub", req_sub, esub);
      chk(wv ? "R1 req_brk" : "R5 req_brk", req_brk, eb);
    end
    wait_vld = 0; io_rd_vld = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset req_vld", req_vld, 0);
    chk("R8 reset io_pass", io_pass, 0);
    rst_n = 1;
    supported = 16'h007F; win_base = 16'h0400; win_range = 16'h0010;
    step(1, 4'd9, 4'd3, 0, 0, 0);             // R3 hint 9 -> 6, sub kept
    step(1, 4'd6, 4'd1, 1, 0, 0);             // R4 exact top
    step(0, 0, 0, 0, 1, 16'h0400);            // R5 window start
    step(0, 0, 0, 0, 1, 16'h040F);            // R5 window end
    step(0, 0, 0, 0, 1, 16'h0410);            // R6 just past
    step(0, 0, 0, 0, 0, 0);                   // R8 idle
    supported = 16'h047F;
    step(1, 4'd9, 4'd5, 0, 0, 0);             // R2 -> 10
    supported = 16'h0081;
    step(0, 0, 0, 0, 1, 16'h0401);            // R5 clip 6 -> 7
    supported = 16'h0000;
    step(1, 4'd3, 4'd2, 1, 0, 0);             // R3 empty mask -> 0
    supported = 16'h0041;
    step(1, 4'd2, 4'd7, 0, 1, 16'h0402);      // R7 explicit wins
    step(1, 4'd0, 4'd0, 0, 1, 16'h0100);      // R7 with pass
    win_base = 16'hFFF0; win_range = 16'h0020;
    step(0, 0, 0, 0, 1, 16'hFFFF);            // R5 top of space
    step(0, 0, 0, 0, 1, 16'h0005);            // R5 no wrap
    win_range = 16'h0000;
    step(0, 0, 0, 0, 1, 16'hFFF0);            // R6 zero range
    for (int k = 0; k < 400; k++) begin
      supported = ($urandom % 8 == 0) ? 16'h0 : 16'($urandom);
      win_base  = 16'($urandom % 64) << ($urandom % 11);
      win_range = 16'($urandom % 40);
      step($urandom % 3 == 0, 4'($urandom), 4'($urandom), 1'($urandom),
           $urandom % 2 == 0, win_base + 16'($urandom % 48) - 16'd4);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule